// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Accumulator Unit

This block holds a 64-bit signed accumulator for 16×16 fixed-point signal processing. Commands arrive on a valid/ready stream. Each command carries an opcode, two 32-bit operands and a 2-bit shift amount. The unit can form a signed product from either the upper or the lower 16-bit halves of the operands. That product is moved 16 places left and then either replaces the accumulator or is added to it. A round-and-clamp operation reduces the accumulator to a saturated 48-bit-range value with its low word cleared. Separate commands load the upper or lower 32-bit half of the accumulator from operand A.

Three read commands return a 32-bit window of the accumulator on a registered response stream: the upper word, a middle word taken from bits 47:16, or the lower word. Every accepted command completes in the cycle it is accepted. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` is high whenever the response slot is empty or is being drained in that same cycle. While `rsp_valid` is high and `rsp_ready` is low, the unit holds the response and stalls all further commands.

Top module: `dspacc_unit`

## Requirements
- R1: After reset the accumulator reads as zero, `rsp_valid` is low and `cmd_ready` is high.
- R2: Opcode 1 (product of upper halves) sign-extends bits 31:16 of A and B, multiplies them, shifts the product left by 16 and overwrites the accumulator.
- R3: Opcode 2 (product of lower halves) does the same as R2 using bits 15:0 of A and B.
- R4: Opcodes 3 (upper halves) and 4 (lower halves) add the same shifted product to the accumulator, and the sum wraps modulo 2^64.
- R5: Opcode 5 (round) shifts the accumulator left by 2 when the shift field is 2, and by 1 for any other shift value. It then adds 2^31 and clears bits 31:0.
- R6: During the round operation, a signed intermediate above 0x00007FFF00000000 becomes exactly that value, and one below 0xFFFF800000000000 becomes exactly that value.
- R7: Opcodes 6, 7 and 8 each return one response. The response data is accumulator bits 63:32, 47:16 or 31:0 respectively, and the accumulator is left unchanged.
- R8: Opcode 9 loads accumulator bits 63:32 from A, and opcode 10 loads bits 31:0 from A. In both cases the other half keeps its value.
- R9: `cmd_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid && !rsp_ready`, the response data holds steady and no command is taken.
- R10: Opcodes other than 6, 7 and 8 produce no response. Opcode 0 and the unused opcodes 11 to 15 leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_a | input | 32 | Operand A |
| cmd_b | input | 32 | Operand B |
| cmd_shift | input | 2 | Round shift amount |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Accumulator slice |

## Verification
The products are tried with the following operand sets:
- mixed-sign upper halves, which separates the upper-half path from the lower-half path;
- a lower half of all ones, which proves sign extension rather than zero extension;
- accumulation near the top of the positive range, which exposes wrap handling.

Rounding is tried with the following accumulator values:
- a value that rounds down, a value that carries into the upper word, and a negative value, which together show the bias and the clearing of the low word;
- values that overflow past each clamp bound, which check the asymmetric limits;
- shift values 0 to 3, which tell the shift-by-2 path from the default shift of 1.

A distinct pattern in each accumulator half checks where the middle slice starts. A held response checks that data stays stable and commands stall.

// File: rtl/dspacc_pkg.sv
package dspacc_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_MULH  = 4'd1,
    OP_MULL  = 4'd2,
    OP_MACH  = 4'd3,
    OP_MACL  = 4'd4,
    OP_RND   = 4'd5,
    OP_RDHI  = 4'd6,
    OP_RDMID = 4'd7,
    OP_RDLO  = 4'd8,
    OP_WRHI  = 4'd9,
    OP_WRLO  = 4'd10
  } acc_op_e;

  function automatic logic is_read(input logic [3:0] op);
    return (op == OP_RDHI) || (op == OP_RDMID) || (op == OP_RDLO);
  endfunction
endpackage

// File: rtl/dspacc_prod.sv
module dspacc_prod #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64
) (
  input  logic [DATA_W-1:0]       a,
  input  logic [DATA_W-1:0]       b,
  input  logic                    use_upper,
  output logic signed [ACC_W-1:0] prod
);
  localparam int HALF_W = DATA_W / 2;

  logic signed [HALF_W-1:0]   ha, hb;
  logic signed [DATA_W-1:0]   raw;
  logic signed [ACC_W-1:0]    wide;

  always_comb begin
    ha   = use_upper ? a[DATA_W-1:HALF_W] : a[HALF_W-1:0];
    hb   = use_upper ? b[DATA_W-1:HALF_W] : b[HALF_W-1:0];
    raw  = ha * hb;
    wide = {{(ACC_W-DATA_W){raw[DATA_W-1]}}, raw};
    prod = wide <<< HALF_W;
  end
endmodule

// File: rtl/dspacc_round.sv
module dspacc_round #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64,
  parameter int SAT_W  = 48
) (
  input  logic signed [ACC_W-1:0] acc_in,
  input  logic [1:0]              shift,
  output logic signed [ACC_W-1:0] acc_out
);
  localparam logic signed [ACC_W-1:0] BIAS =
    {{(ACC_W-DATA_W){1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-DATA_W-1){1'b1}}, {DATA_W{1'b0}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-DATA_W-1){1'b0}}, {DATA_W{1'b0}}};

  logic signed [ACC_W-1:0] shifted, biased;

  always_comb begin
    shifted = (shift == 2'd2) ? (acc_in <<< 2) : (acc_in <<< 1);
    biased  = shifted + BIAS;
    if (biased > SAT_HI)
      acc_out = SAT_HI;
    else if (biased < SAT_LO)
      acc_out = SAT_LO;
    else
      acc_out = {biased[ACC_W-1:DATA_W], {DATA_W{1'b0}}};
  end
endmodule

// File: rtl/dspacc_resp.sv
module dspacc_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              slot_free,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a held response keeps its data
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/dspacc_unit.sv
module dspacc_unit #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64,
  parameter int SAT_W  = 48,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [DATA_W-1:0] cmd_a,
  input  logic [DATA_W-1:0] cmd_b,
  input  logic [1:0]        cmd_shift,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  import dspacc_pkg::*;

  localparam int HALF_W = DATA_W / 2;

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] prod, rnd;
  logic                    take, use_upper, rd_load;
  logic [DATA_W-1:0]       slice;

  assign take      = cmd_valid && cmd_ready;
  assign use_upper = (cmd_op == OP_MULH) || (cmd_op == OP_MACH);
  assign rd_load   = take && is_read(cmd_op);

  dspacc_prod #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_prod (
    .a(cmd_a), .b(cmd_b), .use_upper(use_upper), .prod(prod)
  );

  dspacc_round #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SAT_W(SAT_W)) u_round (
    .acc_in(acc_q), .shift(cmd_shift), .acc_out(rnd)
  );

  always_comb begin
    acc_d = acc_q;
    if (take) begin
      case (cmd_op)
        OP_MULH, OP_MULL: acc_d = prod;
        OP_MACH, OP_MACL: acc_d = acc_q + prod;
        OP_RND:           acc_d = rnd;
        OP_WRHI:          acc_d = {cmd_a, acc_q[DATA_W-1:0]};
        OP_WRLO:          acc_d = {acc_q[ACC_W-1:DATA_W], cmd_a};
        default:          acc_d = acc_q;
      endcase
    end
  end

  always_comb begin
    case (cmd_op)
      OP_RDHI:  slice = acc_q[ACC_W-1:ACC_W-DATA_W];
      OP_RDMID: slice = acc_q[DATA_W+HALF_W-1:HALF_W];
      default:  slice = acc_q[DATA_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  dspacc_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .load_data(slice),
    .slot_free(cmd_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  // R7: reads leave the accumulator untouched
  a_r7_read_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> $stable(acc_q));
  // R5: round leaves the low word clear
  a_r5_round_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_RND) |=> (acc_q[DATA_W-1:0] == '0));
  // R6: round result inside the clamp range
  a_r6_round_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_RND) |=>
      ((acc_q[ACC_W-1:SAT_W-1] == '0) || (acc_q[ACC_W-1:SAT_W-1] == '1)));
  // R8: upper-half load keeps the lower half
  a_r8_wrhi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_WRHI) |=> (acc_q[DATA_W-1:0] == $past(acc_q[DATA_W-1:0])));
  // R10: non-read commands raise no response
  a_r10_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_read(cmd_op) && !rsp_valid) |=> !rsp_valid);
  // R9: no command taken while response stalls
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);
endmodule

// File: tb/test_dspacc_unit.sv
module test_dspacc_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, rsp_valid, rsp_ready = 1'b1;
  logic [3:0] cmd_op = '0;
  logic [31:0] cmd_a = '0, cmd_b = '0, rsp_data;
  logic [1:0] cmd_shift = '0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dspacc_unit i_dspacc_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_shift(cmd_shift),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [1:0] sh);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b; cmd_shift = sh;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic rd(logic [3:0] op, output logic [31:0] d, input string req);
    issue(op, 32'h0, 32'h0, 2'd0);
    @(negedge clk);
    chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    d = rsp_data;
  endtask

  task automatic acc_is(logic [63:0] exp, string req);
    logic [31:0] hi, lo;
    rd(4'd6, hi, req);
    rd(4'd8, lo, req);
    chk(req, {hi, lo}, exp);
  endtask

  task automatic load(logic [63:0] v);
    issue(4'd9, v[63:32], 32'h0, 2'd0);
    issue(4'd10, v[31:0], 32'h0, 2'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
    acc_is(64'h0, "R1 acc");
  endtask

  task automatic t_mul;
    issue(4'd1, 32'h0003_1111, 32'hFFFE_2222, 2'd0);
    @(negedge clk);
    chk("R10 no rsp after product", 64'(rsp_valid), 64'd0);
    acc_is(64'hFFFF_FFFF_FFFA_0000, "R2 upper product");
    issue(4'd2, 32'h7777_FFFF, 32'h1234_0002, 2'd0);
    acc_is(64'hFFFF_FFFF_FFFE_0000, "R3 lower product");
  endtask

  task automatic t_mac;
    issue(4'd1, 32'h0003_0000, 32'h0005_0000, 2'd0);
    issue(4'd3, 32'h0003_0000, 32'h0005_0000, 2'd0);
    issue(4'd4, 32'h0000_0004, 32'h0000_0004, 2'd0);
    acc_is(64'h0000_0000_002E_0000, "R4 accumulate");
    load(64'h7FFF_FFFF_FFFF_FFFF);
    issue(4'd4, 32'h1, 32'h1, 2'd0);
    acc_is(64'h8000_0000_0000_FFFF, "R4 wrap");
  endtask

  task automatic t_round;
    load(64'h0000_1234_8000_0000); issue(4'd5, 0, 0, 2'd1);
    acc_is(64'h0000_2469_0000_0000, "R5 round down");
    load(64'h0000_0000_4000_0000); issue(4'd5, 0, 0, 2'd1);
    acc_is(64'h0000_0001_0000_0000, "R5 round carry");
    load(64'h0000_0001_2000_0000); issue(4'd5, 0, 0, 2'd2);
    acc_is(64'h0000_0005_0000_0000, "R5 shift two");
    load(64'h0000_0001_2000_0000); issue(4'd5, 0, 0, 2'd3);
    acc_is(64'h0000_0002_0000_0000, "R5 shift three as one");
    load(64'h0000_0001_2000_0000); issue(4'd5, 0, 0, 2'd0);
    acc_is(64'h0000_0002_0000_0000, "R5 shift zero as one");
    load(64'hFFFF_FFFF_0000_0000); issue(4'd5, 0, 0, 2'd1);
    acc_is(64'hFFFF_FFFE_0000_0000, "R5 negative");
  endtask

  task automatic t_sat;
    load(64'h0000_4000_0000_0000); issue(4'd5, 0, 0, 2'd1);
    acc_is(64'h0000_7FFF_0000_0000, "R6 upper clamp");
    load(64'hFFFF_C000_0000_0000); issue(4'd5, 0, 0, 2'd2);
    acc_is(64'hFFFF_8000_0000_0000, "R6 lower clamp");
  endtask

  task automatic t_slices;
    logic [31:0] d;
    load(64'h89AB_CDEF_0123_4567);
    rd(4'd7, d, "R7 mid");
    chk("R7 mid slice", 64'(d), 64'hCDEF_0123);
    acc_is(64'h89AB_CDEF_0123_4567, "R7 acc unchanged");
    issue(4'd9, 32'h5555_AAAA, 0, 2'd0);
    acc_is(64'h5555_AAAA_0123_4567, "R8 upper load");
    issue(4'd10, 32'h0F0F_F0F0, 0, 2'd0);
    acc_is(64'h5555_AAAA_0F0F_F0F0, "R8 lower load");
  endtask

  task automatic t_illegal;
    load(64'h1111_2222_3333_4444);
    issue(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2);
    @(negedge clk);
    chk("R10 no rsp unused op", 64'(rsp_valid), 64'd0);
    issue(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2);
    issue(4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2);
    acc_is(64'h1111_2222_3333_4444, "R10 acc unchanged");
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    load(64'hAAAA_0000_0000_BBBB);
    rsp_ready = 1'b0;
    issue(4'd6, 0, 0, 2'd0);
    @(negedge clk);
    chk("R9 rsp up", 64'(rsp_valid), 64'd1);
    held = rsp_data;
    chk("R9 held data", 64'(held), 64'hAAAA_0000);
    cmd_valid = 1'b1; cmd_op = 4'd9; cmd_a = 32'h1234_5678;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 stalled", 64'(cmd_ready), 64'd0);
      chk("R9 stable", 64'(rsp_data), 64'(held));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 slot drained", 64'(rsp_valid), 64'd0);
    cmd_valid = 1'b0;
    acc_is(64'h1234_5678_0000_BBBB, "R9 stalled cmd taken once free");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_mul;
    t_mac;
    t_round;
    t_sat;
    t_slices;
    t_illegal;
    t_backpressure;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule